// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit and Selectable Read Timing

This block is a first-in first-out buffer whose write port and read port run on two unrelated clocks. Words enter on the write clock when the write enable is high and leave on the read clock. Each side keeps its own binary pointer. The pointer crosses to the other side as a Gray code through a chain of synchronizer flops. Every status flag is computed from one local pointer and one synchronized pointer. The clock frequencies need not have any fixed ratio.

Two read-side timing styles are available, and the choice is captured while master reset is held. In standard timing, the read-side flag means "empty" and the write-side flag means "full", and a word reaches the output only after a read request. In fall-through timing, the read-side flag means "a word is waiting on the output" and the write-side flag means "space is available". The oldest word moves onto the output on its own. A read request then consumes that word. A partial reset empties the buffer but keeps the captured timing style. A retransmit request moves the read position back to storage location zero, so everything written since the last reset can be read again. The almost-empty and almost-full thresholds come in as inputs from a neighbouring block. The output-enable pin gates a valid qualifier, which stands in for a tri-state data bus.

Top module: `rt_fifo`

## Requirements
- R1: Words come out in the order they were written, with no loss or duplication, while the write clock and the read clock run at unrelated rates.
- R2: While `mrst` is high, both pointers return to zero and `fwft_sel` is captured as the timing style (0 = standard, 1 = fall-through). After release, standard style shows `rd_flag`=1 and `wr_flag`=0, fall-through style shows `rd_flag`=0 and `wr_flag`=1, and in both styles `half_full`=0, `almost_empty`=1 and `q_valid`=0.
- R3: `prst` clears the stored data and both pointers exactly as `mrst` does, but it does not sample `fwft_sel`. The timing style captured at the last master reset stays in force.
- R4: In standard style, `rd_flag` is 1 exactly when no unread word is stored, and `wr_flag` is 1 exactly when DEPTH words are stored. A read accepted at a read-clock edge places the next word on `q` at that same edge.
- R5: In fall-through style, `rd_flag` is 1 while a word is held on `q`, and the oldest stored word is loaded without any `rd_en`. `rd_en` with `rd_flag`=1 consumes the held word at that edge. `wr_flag` is 1 while storage has room, so the capacity is DEPTH+1 words when the held word is counted.
- R6: When a word is written into an empty buffer at write-clock edge T, the standard `rd_flag` falls no later than the second read-clock edge after T. In fall-through style, `rd_flag` rises with that word on `q` no later than the third read-clock edge after T.
- R7: `half_full` is 1 exactly when the write side counts more than DEPTH/2 words in storage, not counting a word already moved to the output.
- R8: `almost_empty` is 1 when the count of stored words not yet moved to the output is at most `ae_ofs`. `almost_full` is 1 when the number of free storage locations is at most `af_ofs`.
- R9: `rt` high at a read-clock edge sets the read position to location zero. In fall-through style, `rd_flag` is 0 after that edge, and the first word written since the last reset is on `q` with `rd_flag`=1 after the following edge. In standard style, the next accepted read returns that first word. Retransmit is valid while fewer than DEPTH words have been written since the last reset.
- R10: A write while storage is full and a standard-style read while empty are ignored. The pointers are unchanged and `q` keeps its value.
- R11: `q_valid` equals `oe` ANDed with "a word is held". A word is held after an accepted read in standard style, or while `rd_flag`=1 in fall-through style. Reset and retransmit clear the held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, active high, asserts asynchronously, captures timing style |
| prst | input | 1 | Partial reset, active high, keeps timing style |
| fwft_sel | input | 1 | Timing style captured during master reset (1 = fall-through) |
| wen | input | 1 | Write request, write clock domain |
| din | input | DATA_W | Write data |
| rd_en | input | 1 | Read request, read clock domain |
| rt | input | 1 | Retransmit request, read clock domain |
| oe | input | 1 | Output enable gating `q_valid` |
| ae_ofs | input | ADDR_W | Almost-empty threshold |
| af_ofs | input | ADDR_W | Almost-full threshold |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| half_full | output | 1 | More than DEPTH/2 words stored, write domain |
| almost_full | output | 1 | Free locations at most `af_ofs`, write domain |
| almost_empty | output | 1 | Unfetched words at most `ae_ofs`, read domain |
| q | output | DATA_W | Read data register |
| q_valid | output | 1 | Data-valid qualifier standing in for a tri-state enable |

## Verification
A pointer that is wrong on either side shows up at the ports as data out of order, repeated or missing. Because each word carries a running sequence number, the first word read after the fault exposes it. A synchronized pointer that is stale or corrupted shows up as a wrong flag: a full, half or almost flag that is wrong once the opposite clock has run a few cycles, or an empty flag that stays set past its R6 bound. A timing style that was captured wrongly, or lost in a partial reset, inverts the meaning of both flags in the first cycle after reset release. A retransmit that fails to rewind puts the wrong word on `q` within two read-clock edges.

// File: rtl/rt_fifo_pkg.sv
package rt_fifo_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } mode_e;

endpackage

// File: rtl/rt_fifo_sync.sv
module rt_fifo_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rt_fifo_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("rt_fifo_sync: WIDTH must be at least 1");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) stg <= '0;
      else     stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/rt_fifo_mem.sv
module rt_fifo_mem #(
   parameter int DATA_W = 18,
   parameter int ADDR_W = 10
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rclk,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   // The read register is also the block's output register.
   always_ff @(posedge rclk) begin
      if (re) rdata <= cells[raddr];
   end

endmodule

// File: rtl/rt_fifo_wctl.sv
module rt_fifo_wctl
   import rt_fifo_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  mode_e             mode,
   input  logic              wen,
   input  logic [ADDR_W:0]   rgray_s,
   input  logic [ADDR_W-1:0] af_ofs,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W:0]   wgray,
   output logic              wr_flag,
   output logic              half_full,
   output logic              almost_full
);

   localparam int PTR_W = ADDR_W + 1;
   localparam logic [PTR_W-1:0] DEPTH = PTR_W'(1) << ADDR_W;
   localparam logic [PTR_W-1:0] HALF  = DEPTH >> 1;

   logic [PTR_W-1:0] wbin, wbin_nx, rbin_s, used, spare;
   logic             full;

   always_comb begin
      rbin_s[PTR_W-1] = rgray_s[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--) begin
         rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
      end
   end

   assign used    = wbin - rbin_s;
   assign spare   = DEPTH - used;
   assign full    = (used == DEPTH);
   assign we      = wen & ~full;
   assign wbin_nx = wbin + PTR_W'(we);
   assign waddr   = wbin[ADDR_W-1:0];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   assign wr_flag     = (mode == MODE_FWFT) ? ~full : full;
   assign half_full   = used > HALF;
   assign almost_full = spare <= {1'b0, af_ofs};

endmodule

// File: rtl/rt_fifo_rctl.sv
module rt_fifo_rctl
   import rt_fifo_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  mode_e             mode,
   input  logic              ren,
   input  logic              rt,
   input  logic [ADDR_W:0]   wgray_s,
   input  logic [ADDR_W-1:0] ae_ofs,
   output logic              fetch,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rgray,
   output logic              rd_flag,
   output logic              almost_empty,
   output logic              held
);

   localparam int PTR_W = ADDR_W + 1;

   logic [PTR_W-1:0] rbin, rbin_nx, wbin_s, avail;
   logic             mem_empty, want;

   always_comb begin
      wbin_s[PTR_W-1] = wgray_s[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--) begin
         wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
      end
   end

   assign avail     = wbin_s - rbin;
   assign mem_empty = (avail == '0);
   assign want      = (mode == MODE_FWFT) ? (~held | ren) : ren;
   assign fetch     = ~rt & ~mem_empty & want;
   assign rbin_nx   = rt ? '0 : rbin + PTR_W'(fetch);
   assign raddr     = rbin[ADDR_W-1:0];

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rbin  <= '0;
         rgray <= '0;
         held  <= 1'b0;
      end else begin
         rbin  <= rbin_nx;
         rgray <= rbin_nx ^ (rbin_nx >> 1);
         if (rt)                               held <= 1'b0;
         else if (fetch)                       held <= 1'b1;
         else if (mode == MODE_FWFT && ren)    held <= 1'b0;
      end
   end

   assign rd_flag      = (mode == MODE_FWFT) ? held : mem_empty;
   assign almost_empty = avail <= {1'b0, ae_ofs};

endmodule

// File: rtl/rt_fifo.sv
module rt_fifo
   import rt_fifo_pkg::*;
#(
   parameter int DATA_W      = 18,
   parameter int ADDR_W      = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              fwft_sel,
   input  logic              wen,
   input  logic [DATA_W-1:0] din,
   input  logic              rd_en,
   input  logic              rt,
   input  logic              oe,
   input  logic [ADDR_W-1:0] ae_ofs,
   input  logic [ADDR_W-1:0] af_ofs,
   output logic              wr_flag,
   output logic              rd_flag,
   output logic              half_full,
   output logic              almost_full,
   output logic              almost_empty,
   output logic [DATA_W-1:0] q,
   output logic              q_valid
);

   localparam int PTR_W = ADDR_W + 1;

   if (DATA_W < 1) begin : g_bad_data_w
      $error("rt_fifo: DATA_W must be at least 1");
   end
   if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr_w
      $error("rt_fifo: ADDR_W must lie in 2..16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("rt_fifo: SYNC_STAGES must be at least 2");
   end

   // Reset: asserted asynchronously, released on each domain's own clock.
   logic       rst_any;
   logic [1:0] w_rs, r_rs;
   logic       wrst, rrst;

   assign rst_any = mrst | prst;

   always_ff @(posedge wclk or posedge rst_any) begin
      if (rst_any) w_rs <= 2'b11;
      else         w_rs <= {w_rs[0], 1'b0};
   end

   always_ff @(posedge rclk or posedge rst_any) begin
      if (rst_any) r_rs <= 2'b11;
      else         r_rs <= {r_rs[0], 1'b0};
   end

   assign wrst = w_rs[1];
   assign rrst = r_rs[1];

   // Timing style: each domain samples the selector only during master reset.
   mode_e w_mode, r_mode;

   always_ff @(posedge wclk) begin
      if (mrst) w_mode <= mode_e'(fwft_sel);
   end

   always_ff @(posedge rclk) begin
      if (mrst) r_mode <= mode_e'(fwft_sel);
   end

   logic [PTR_W-1:0]  w_gray, r_gray, w_gray_s, r_gray_s;
   logic [ADDR_W-1:0] waddr, raddr;
   logic              we, fetch, held;

   rt_fifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
      .clk (rclk),
      .rst (rrst),
      .d   (w_gray),
      .q   (w_gray_s)
   );

   rt_fifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
      .clk (wclk),
      .rst (wrst),
      .d   (r_gray),
      .q   (r_gray_s)
   );

   rt_fifo_wctl #(.ADDR_W(ADDR_W)) u_wctl (
      .clk         (wclk),
      .rst         (wrst),
      .mode        (w_mode),
      .wen         (wen),
      .rgray_s     (r_gray_s),
      .af_ofs      (af_ofs),
      .we          (we),
      .waddr       (waddr),
      .wgray       (w_gray),
      .wr_flag     (wr_flag),
      .half_full   (half_full),
      .almost_full (almost_full)
   );

   rt_fifo_rctl #(.ADDR_W(ADDR_W)) u_rctl (
      .clk          (rclk),
      .rst          (rrst),
      .mode         (r_mode),
      .ren          (rd_en),
      .rt           (rt),
      .wgray_s      (w_gray_s),
      .ae_ofs       (ae_ofs),
      .fetch        (fetch),
      .raddr        (raddr),
      .rgray        (r_gray),
      .rd_flag      (rd_flag),
      .almost_empty (almost_empty),
      .held         (held)
   );

   rt_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
      .wclk  (wclk),
      .we    (we),
      .waddr (waddr),
      .wdata (din),
      .rclk  (rclk),
      .re    (fetch),
      .raddr (raddr),
      .rdata (q)
   );

   assign q_valid = oe & held;

endmodule

// File: rtl/rt_fifo_chk.sv
module rt_fifo_chk #(
   parameter int PTR_W = 11
) (
   input logic             wclk,
   input logic             rclk,
   input logic             wrst,
   input logic             rrst,
   input logic             w_mode,
   input logic             r_mode,
   input logic             wen,
   input logic             rd_en,
   input logic             rt,
   input logic             wr_flag,
   input logic             rd_flag,
   input logic             half_full,
   input logic [PTR_W-1:0] w_gray,
   input logic [PTR_W-1:0] r_gray
);

   // R1
   wgray_step_chk: assert property (@(posedge wclk) disable iff (wrst)
      $countones(w_gray ^ $past(w_gray)) <= 1);

   // R9
   rgray_step_chk: assert property (@(posedge rclk) disable iff (rrst)
      !$past(rt) |-> $countones(r_gray ^ $past(r_gray)) <= 1);

   // R10
   no_overflow_chk: assert property (@(posedge wclk) disable iff (wrst)
      (!w_mode && wr_flag && wen) |=> $stable(w_gray));

   // R10
   no_overflow_fwft_chk: assert property (@(posedge wclk) disable iff (wrst)
      (w_mode && !wr_flag && wen) |=> $stable(w_gray));

   // R10
   no_underflow_chk: assert property (@(posedge rclk) disable iff (rrst)
      (!r_mode && rd_flag && rd_en && !rt) |=> $stable(r_gray));

   // R9
   rt_flush_chk: assert property (@(posedge rclk) disable iff (rrst)
      (r_mode && $past(rt)) |-> !rd_flag);

   // R7
   full_half_chk: assert property (@(posedge wclk) disable iff (wrst)
      (!w_mode && wr_flag) |-> half_full);

endmodule

bind rt_fifo rt_fifo_chk #(.PTR_W(ADDR_W + 1)) u_chk (
   .wclk      (wclk),
   .rclk      (rclk),
   .wrst      (wrst),
   .rrst      (rrst),
   .w_mode    (w_mode),
   .r_mode    (r_mode),
   .wen       (wen),
   .rd_en     (rd_en),
   .rt        (rt),
   .wr_flag   (wr_flag),
   .rd_flag   (rd_flag),
   .half_full (half_full),
   .w_gray    (w_gray),
   .r_gray    (r_gray)
);

// File: tb/rt_fifo_test.sv
module rt_fifo_test;

   localparam int CLK_PERIOD  = 10;
   localparam int RCLK_PERIOD = 14;
   localparam int DW          = 18;
   localparam int AW          = 4;
   localparam int DEPTH       = 1 << AW;
   localparam int NVEC        = 9;

   typedef struct packed {
      int unsigned nw;
      int unsigned nr;
      logic        full;
      logic        empty;
      logic        half;
      logic        ae;
      logic        af;
   } vec_t;

   // Standard style, ae_ofs=2, af_ofs=3; counts are cumulative.
   localparam vec_t VEC [NVEC] = '{
      '{1, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},   // 1
      '{8, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},   // 9
      '{4, 0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},   // 13
      '{3, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},   // 16
      '{2, 0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},   // 16, writes ignored
      '{0, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},   // 8
      '{0, 6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},   // 2
      '{0, 2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},   // 0
      '{0, 2, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}    // 0, reads ignored
   };

   logic          wclk = 1'b0, rclk = 1'b0;
   logic          mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0;
   logic          wen = 1'b0, rd_en = 1'b0, rt = 1'b0, oe = 1'b1;
   logic [DW-1:0] din = '0;
   logic [AW-1:0] ae_ofs = AW'(2), af_ofs = AW'(3);
   logic          wr_flag, rd_flag, half_full, almost_full, almost_empty, q_valid;
   logic [DW-1:0] q;

   rt_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) uut (
      .wclk(wclk), .rclk(rclk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
      .wen(wen), .din(din), .rd_en(rd_en), .rt(rt), .oe(oe),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs), .wr_flag(wr_flag), .rd_flag(rd_flag),
      .half_full(half_full), .almost_full(almost_full), .almost_empty(almost_empty),
      .q(q), .q_valid(q_valid)
   );

   always #(CLK_PERIOD / 2)  wclk = ~wclk;
   always #(RCLK_PERIOD / 2) rclk = ~rclk;

   int            checks = 0, fails = 0, cap = DEPTH;
   logic [DW-1:0] wseq = DW'(16'h0a00);
   logic [DW-1:0] last = '0;
   logic [DW-1:0] model [$];
   logic [DW-1:0] hist  [$];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (6) @(negedge wclk);
      repeat (6) @(negedge rclk);
   endtask

   task automatic do_reset(input logic master, input logic sel);
      @(negedge wclk);
      fwft_sel = sel;
      wen = 1'b0; rd_en = 1'b0; rt = 1'b0;
      if (master) mrst = 1'b1;
      else        prst = 1'b1;
      repeat (4) @(negedge rclk);
      repeat (4) @(negedge wclk);
      mrst = 1'b0;
      prst = 1'b0;
      model.delete();
      hist.delete();
      settle();
   endtask

   task automatic write_word();
      @(negedge wclk);
      wen = 1'b1;
      din = wseq;
      @(negedge wclk);
      wen = 1'b0;
      if (model.size() < cap) begin
         model.push_back(wseq);
         hist.push_back(wseq);
      end
      wseq++;
   endtask

   // Standard style read: q changes at the edge that accepts the read.
   task automatic std_read();
      @(negedge rclk);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      if (model.size() > 0) begin
         last = model.pop_front();
         chk("R1 R4 std read order", 32'(q), 32'(last));
      end else begin
         chk("R10 read while empty keeps q", 32'(q), 32'(last));
      end
   endtask

   // Fall-through pop: the next word is loaded at the consuming edge.
   task automatic fwft_pop();
      @(negedge rclk);
      rd_en = 1'b1;
      @(negedge rclk);
      rd_en = 1'b0;
      if (model.size() > 0) void'(model.pop_front());
      if (model.size() > 0) begin
         chk("R5 fwft pop flag", 32'(rd_flag), 32'd1);
         chk("R1 R5 fwft pop data", 32'(q), 32'(model[0]));
      end else begin
         chk("R5 R10 fwft drained", 32'(rd_flag), 32'd0);
      end
   endtask

   task automatic pulse_rt(input logic fwft);
      @(negedge rclk);
      rt = 1'b1;
      @(negedge rclk);
      rt = 1'b0;
      model = hist;
      if (fwft) begin
         chk("R9 rt clears output-ready", 32'(rd_flag), 32'd0);
         @(negedge rclk);
         chk("R9 rt refetch flag", 32'(rd_flag), 32'd1);
         chk("R9 rt refetch data", 32'(q), 32'(hist[0]));
      end else begin
         chk("R9 R11 rt clears valid", 32'(q_valid), 32'd0);
      end
   endtask

   // Write one word into an empty buffer and bound the flag latency.
   task automatic latency_probe(input logic fwft);
      @(negedge wclk);
      wen = 1'b1;
      din = wseq;
      @(posedge wclk);
      #1;
      wen = 1'b0;
      model.push_back(wseq);
      hist.push_back(wseq);
      wseq++;
      repeat (fwft ? 3 : 2) @(posedge rclk);
      @(negedge rclk);
      if (fwft) begin
         chk("R6 fwft first-word flag", 32'(rd_flag), 32'd1);
         chk("R6 fwft first-word data", 32'(q), 32'(model[0]));
      end else begin
         chk("R6 std empty release", 32'(rd_flag), 32'd0);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge wclk);
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      do_reset(1'b1, 1'b0);

      // R2 reset state, standard style
      chk("R2 wr_flag", 32'(wr_flag), 32'd0);
      chk("R2 rd_flag", 32'(rd_flag), 32'd1);
      chk("R2 half_full", 32'(half_full), 32'd0);
      chk("R2 almost_empty", 32'(almost_empty), 32'd1);
      chk("R2 almost_full", 32'(almost_full), 32'd0);
      chk("R2 q_valid", 32'(q_valid), 32'd0);

      latency_probe(1'b0);
      settle();
      std_read();
      chk("R11 q_valid with oe", 32'(q_valid), 32'd1);
      oe = 1'b0;
      #1;
      chk("R11 q_valid without oe", 32'(q_valid), 32'd0);
      oe = 1'b1;

      // Vector table in standard style
      do_reset(1'b1, 1'b0);
      for (int i = 0; i < NVEC; i++) begin
         for (int k = 0; k < int'(VEC[i].nw); k++) write_word();
         for (int k = 0; k < int'(VEC[i].nr); k++) std_read();
         settle();
         chk("R4 R10 full flag", 32'(wr_flag), 32'(VEC[i].full));
         chk("R4 empty flag", 32'(rd_flag), 32'(VEC[i].empty));
         chk("R7 half_full", 32'(half_full), 32'(VEC[i].half));
         chk("R8 almost_empty", 32'(almost_empty), 32'(VEC[i].ae));
         chk("R8 almost_full", 32'(almost_full), 32'(VEC[i].af));
      end

      // Retransmit, standard style
      do_reset(1'b1, 1'b0);
      for (int k = 0; k < 3; k++) write_word();
      settle();
      std_read();
      std_read();
      pulse_rt(1'b0);
      settle();
      std_read();
      std_read();

      // Fall-through style
      do_reset(1'b1, 1'b1);
      cap = DEPTH + 1;
      chk("R2 R5 fwft wr_flag", 32'(wr_flag), 32'd1);
      chk("R2 R5 fwft rd_flag", 32'(rd_flag), 32'd0);
      chk("R2 fwft q_valid", 32'(q_valid), 32'd0);
      latency_probe(1'b1);
      chk("R11 fwft q_valid", 32'(q_valid), 32'd1);
      for (int k = 0; k < 3; k++) write_word();
      settle();
      chk("R8 fwft almost_empty excludes held word", 32'(almost_empty), 32'd0);
      for (int k = 0; k < 5; k++) fwft_pop();
      pulse_rt(1'b1);
      fwft_pop();

      // Partial reset keeps fall-through style despite fwft_sel=0
      do_reset(1'b0, 1'b0);
      chk("R3 style kept wr_flag", 32'(wr_flag), 32'd1);
      chk("R3 style kept rd_flag", 32'(rd_flag), 32'd0);
      write_word();
      settle();
      chk("R3 fall-through after prst", 32'(rd_flag), 32'd1);
      chk("R3 data after prst", 32'(q), 32'(model[0]));
      for (int k = 0; k < DEPTH + 1; k++) write_word();
      settle();
      chk("R5 R10 fwft full", 32'(wr_flag), 32'd0);
      for (int k = 0; k < DEPTH + 1; k++) fwft_pop();

      // Master reset picks standard style again
      cap = DEPTH;
      do_reset(1'b1, 1'b0);
      chk("R2 standard after mrst", 32'(rd_flag), 32'd1);
      chk("R2 not full after mrst", 32'(wr_flag), 32'd0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule